// File: doc/BRIEF.md
# Page-Buffered Byte Store with Region Write Protection

This block sits in front of a 512-byte storage array arranged as 32 pages of 16 bytes. A client drives one command per cycle: a read, the opening of a write sequence with its first byte, further data bytes for that sequence, or the closing of the sequence. Bytes of an open sequence collect in a one-page staging buffer. Closing the sequence starts a timed commit. During the commit the staged bytes are copied into the array one per cycle, and a busy interval that stands in for the self-timed non-volatile programming time is enforced.

A 3-bit protection code, captured when a sequence closes, selects one of eight regions: none, the top quarter, the top half, the whole array, or the first 4, 8 or 16 pages. Bytes that fall into the selected region are dropped without disturbing the array. A flag reports, once the commit has finished, whether any byte was dropped. Reads are served from the array whenever the block is idle. While it is busy, every command is refused and the read data holds its last value.

Top module: `pagemem_ctrl`

## Requirements
- R1: After synchronous reset `busy`, `wp_reject` and `rd_data` are all 0.
- R2: A command (`cmd_valid`=1) is decoded from `cmd_op`: 0 = read, 1 = open write, 2 = write data, 3 = close write. An accepted read of `cmd_addr` presents the array byte on `rd_data` from the following cycle on, and `rd_data` holds until the next accepted read.
- R3: Opening a sequence at an address and closing it with no data commands writes exactly that one byte. All other bytes of the page keep their contents.
- R4: Inside a sequence the byte offset (address bits 3:0) advances by one per data command and wraps from 15 to 0 within the same page (address bits 8:4, fixed by the open command). A later byte at an offset already loaded replaces the earlier one. Offsets that were never loaded keep their array contents.
- R5: An accepted close raises `busy` in the next cycle and keeps it high for exactly `WC_CYCLES` cycles.
- R6: While `busy` is high, every command is ignored. Write commands change neither the array nor the open sequence, and reads leave `rd_data` unchanged.
- R7: Protection codes (`prot_code`, sampled at the accepted close): 0 none; 1 addresses 0x180–0x1FF; 2 0x100–0x1FF; 3 all; 4 0x000–0x03F; 5 0x000–0x07F; 6 0x000–0x0FF; 7 all.
- R8: Protection is evaluated per staged byte during the commit. Protected bytes leave the array unchanged, and unprotected bytes of the same commit are still written.
- R9: `wp_reject` updates in the cycle `busy` falls: it goes to 1 if any staged byte of that commit was dropped and to 0 otherwise. An accepted open command clears it. In all other cycles it holds.
- R10: Data or close commands with no open sequence are ignored and do not raise `busy`. An open command while a sequence is already open discards the bytes staged so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_addr | input | ADDR_W | Byte address for read and open commands |
| cmd_data | input | DATA_W | Byte for open and data commands |
| prot_code | input | 3 | Protection region select, captured at close |
| rd_data | output | DATA_W | Registered read data |
| busy | output | 1 | Commit interval in progress |
| wp_reject | output | 1 | Last commit dropped at least one protected byte |

## Verification
The hardest case to reach from the ports is a command that arrives while the commit timer is running. Such a command has to be observed to have no effect, both on the array and on the staged sequence it could have corrupted. The stimulus closes a page write and, inside the busy window, issues a read of a freshly committed address, an open, data bytes and a close. It also changes the protection code. After busy falls it reads back both the committed page and the page the refused sequence aimed at. The refused read must not have moved `rd_data`, and the committed bytes must follow the code that was captured at the close.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_READ   = 2'd0,
    PM_WOPEN  = 2'd1,
    PM_WDATA  = 2'd2,
    PM_WCLOSE = 2'd3
  } pm_op_e;
endpackage

// File: rtl/pm_protect_decode.sv
// Maps a 3-bit region code and an address to a protected/unprotected verdict.
module pm_protect_decode #(
  parameter int ADDR_W = 9,
  parameter int OFS_W  = 4
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic top_quarter, top_half, first4, first8, first16;

  always_comb begin
    top_quarter = (addr[ADDR_W-1 -: 2] == 2'b11);
    top_half    = addr[ADDR_W-1];
    first4      = ((addr >> (OFS_W + 2)) == '0);
    first8      = ((addr >> (OFS_W + 3)) == '0);
    first16     = ((addr >> (OFS_W + 4)) == '0);
    unique case (code)
      3'd0:    hit = 1'b0;
      3'd1:    hit = top_quarter;
      3'd2:    hit = top_half;
      3'd4:    hit = first4;
      3'd5:    hit = first8;
      3'd6:    hit = first16;
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/pm_page_buffer.sv
// One-page staging buffer with an offset pointer that wraps inside the page.
module pm_page_buffer #(
  parameter int DATA_W = 8,
  parameter int OFS_W  = 4,
  parameter int PAGE_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    open_i,
  input  logic                    load_i,
  input  logic [PAGE_W+OFS_W-1:0] open_addr,
  input  logic [DATA_W-1:0]       din,
  input  logic [OFS_W-1:0]        sel,
  output logic [PAGE_W-1:0]       page,
  output logic [DATA_W-1:0]       dout,
  output logic                    dvalid
);
  localparam int DEPTH = 1 << OFS_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [OFS_W-1:0]  ptr_q;
  logic [OFS_W-1:0]  open_ofs;
  logic [OFS_W-1:0]  wr_idx;

  assign open_ofs = open_addr[OFS_W-1:0];
  assign wr_idx   = open_i ? open_ofs : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      ptr_q <= '0;
      page  <= '0;
    end else if (open_i) begin
      page  <= open_addr[PAGE_W+OFS_W-1:OFS_W];
      ptr_q <= open_ofs + OFS_W'(1);
      vld_q <= DEPTH'(1) << open_ofs;
    end else if (load_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= ptr_q + OFS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (open_i || load_i) data_q[wr_idx] <= din;
  end

  assign dout   = data_q[sel];
  assign dvalid = vld_q[sel];
endmodule

// File: rtl/pm_cycle_timer.sv
// Busy interval of WC_CYCLES cycles; the first 2**OFS_W cycles step the commit index.
module pm_cycle_timer #(
  parameter int WC_CYCLES = 600000,
  parameter int OFS_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  output logic             busy,
  output logic             step_en,
  output logic [OFS_W-1:0] step_idx,
  output logic             done
);
  localparam int CNT_W = $clog2(WC_CYCLES + 1);
  localparam int STEPS = 1 << OFS_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (launch) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (done) busy <= 1'b0;
    end
  end

  assign done     = busy && (cnt_q == CNT_W'(WC_CYCLES - 1));
  assign step_en  = busy && (cnt_q < CNT_W'(STEPS));
  assign step_idx = cnt_q[OFS_W-1:0];
endmodule

// File: rtl/pm_array.sv
// Simple dual-port array: one write port, one registered read port.
module pm_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pagemem_ctrl.sv
module pagemem_ctrl #(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WC_CYCLES  = 600000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [2:0]        prot_code,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              wp_reject
);
  import pm_pkg::*;

  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  pm_op_e            op;
  logic              accept, do_read, do_open, do_load, do_close;
  logic              seq_open;
  logic [2:0]        prot_lat;
  logic [PAGE_W-1:0] buf_page;
  logic [DATA_W-1:0] buf_byte;
  logic              buf_vld;
  logic              step_en, done;
  logic [OFS_W-1:0]  step_idx;
  logic [ADDR_W-1:0] commit_addr;
  logic              prot_hit, step_write, mem_we, step_rej, rej_acc;

  assign op       = pm_op_e'(cmd_op);
  assign accept   = cmd_valid && !busy;
  assign do_read  = accept && (op == PM_READ);
  assign do_open  = accept && (op == PM_WOPEN);
  assign do_load  = accept && (op == PM_WDATA)  && seq_open;
  assign do_close = accept && (op == PM_WCLOSE) && seq_open;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_open <= 1'b0;
      prot_lat <= '0;
    end else begin
      if (do_open)       seq_open <= 1'b1;
      else if (do_close) seq_open <= 1'b0;
      if (do_close)      prot_lat <= prot_code;
    end
  end

  pm_page_buffer #(.DATA_W(DATA_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst(rst), .open_i(do_open), .load_i(do_load),
    .open_addr(cmd_addr), .din(cmd_data), .sel(step_idx),
    .page(buf_page), .dout(buf_byte), .dvalid(buf_vld)
  );

  pm_cycle_timer #(.WC_CYCLES(WC_CYCLES), .OFS_W(OFS_W)) u_tmr (
    .clk(clk), .rst(rst), .launch(do_close), .busy(busy),
    .step_en(step_en), .step_idx(step_idx), .done(done)
  );

  assign commit_addr = {buf_page, step_idx};

  pm_protect_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_prot (
    .code(prot_lat), .addr(commit_addr), .hit(prot_hit)
  );

  assign step_write = step_en && buf_vld;
  assign mem_we     = step_write && !prot_hit;
  assign step_rej   = step_write && prot_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rej_acc   <= 1'b0;
      wp_reject <= 1'b0;
    end else begin
      if (do_close)      rej_acc <= 1'b0;
      else if (step_rej) rej_acc <= 1'b1;
      if (do_open)       wp_reject <= 1'b0;
      else if (done)     wp_reject <= rej_acc || step_rej;
    end
  end

  pm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(commit_addr), .wdata(buf_byte),
    .re(do_read), .raddr(cmd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int DATA_W    = 8,
  parameter int WC_CYCLES = 600000
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              seq_open,
  input logic              busy,
  input logic              wp_reject,
  input logic [DATA_W-1:0] rd_data,
  input logic              mem_we,
  input logic              prot_hit
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3 && seq_open && !busy) |=> busy);

  a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_run == WC_CYCLES));

  a_r5_busy_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < WC_CYCLES));

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data));

  a_r8_no_protected_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (!prot_hit && busy));

  a_r9_open_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && !busy) |=> !wp_reject);

  a_r10_no_stray_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cmd_valid && cmd_op == 2'd3 && seq_open)) |=> !busy);
endmodule

bind pagemem_ctrl pm_checker #(.DATA_W(DATA_W), .WC_CYCLES(WC_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .seq_open(seq_open), .busy(busy), .wp_reject(wp_reject), .rd_data(rd_data),
  .mem_we(mem_we), .prot_hit(prot_hit)
);

// File: tb/tb_pagemem_ctrl.sv
module tb_pagemem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WC         = 40;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [8:0] cmd_addr = '0;
  logic [7:0] cmd_data = '0;
  logic [2:0] prot_code = 3'd0;
  logic [7:0] rd_data;
  logic       busy, wp_reject;

  pagemem_ctrl #(.WC_CYCLES(WC)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prot_code(prot_code),
    .rd_data(rd_data), .busy(busy), .wp_reject(wp_reject)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  string tag = "R1";

  // Behavioural reference model
  int m_mem [512];
  bit m_known [512];
  int m_buf [16];
  bit m_bv [16];
  int m_page, m_ptr, m_cnt, m_prot;
  bit m_open, m_busy, m_rej, m_pend_rej;
  int m_rd;
  bit m_rd_known;

  function automatic bit prot_region(int code, int a);
    case (code)
      1: return a >= 384;
      2: return a >= 256;
      3: return 1;
      4: return a < 64;
      5: return a < 128;
      6: return a < 256;
      7: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_open = 0; m_busy = 0; m_rej = 0; m_rd = 0; m_rd_known = 1; m_cnt = 0;
    end else if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_pend_rej = 0;
        for (int i = 0; i < 16; i++) begin
          if (m_bv[i]) begin
            if (prot_region(m_prot, m_page*16 + i)) m_pend_rej = 1;
            else begin
              m_mem[m_page*16 + i] = m_buf[i];
              m_known[m_page*16 + i] = 1;
            end
          end
        end
        m_rej = m_pend_rej;
        m_busy = 0;
      end
    end else if (cmd_valid) begin
      case (cmd_op)
        2'd0: begin m_rd = m_mem[cmd_addr]; m_rd_known = m_known[cmd_addr]; end
        2'd1: begin
          for (int i = 0; i < 16; i++) m_bv[i] = 0;
          m_page = cmd_addr / 16;
          m_buf[cmd_addr % 16] = cmd_data;
          m_bv[cmd_addr % 16] = 1;
          m_ptr = (cmd_addr % 16 + 1) % 16;
          m_open = 1; m_rej = 0;
        end
        2'd2: if (m_open) begin
          m_buf[m_ptr] = cmd_data; m_bv[m_ptr] = 1; m_ptr = (m_ptr + 1) % 16;
        end
        default: if (m_open) begin
          m_open = 0; m_busy = 1; m_cnt = WC; m_prot = prot_code;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst || tag == "R1") begin
      checks++;
      if (busy !== m_busy) begin
        failures++;
        $display("FAIL %s busy act=%0d exp=%0d t=%0t", (tag == "R1") ? tag : "R5", busy, m_busy, $time);
      end
      checks++;
      if (wp_reject !== m_rej) begin
        failures++;
        $display("FAIL %s wp_reject act=%0d exp=%0d t=%0t", (tag == "R1") ? tag : "R9", wp_reject, m_rej, $time);
      end
      if (m_rd_known) begin
        checks++;
        if (rd_data !== 8'(m_rd)) begin
          failures++;
          $display("FAIL %s rd_data act=%0h exp=%0h t=%0t", tag, rd_data, m_rd, $time);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cmd(input int op, input int a, input int d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = 9'(a); cmd_data = 8'(d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  task automatic wait_free();
    idle(1);
    while (busy) idle(1);
  endtask

  task automatic page_write(input int page, input int ofs, input int n, input int seed);
    cmd(1, page*16 + ofs, (page*16 + ofs) * 7 + seed);
    for (int i = 1; i < n; i++) cmd(2, 0, (page*16 + (ofs + i) % 16) * 7 + seed + i / 16);
    cmd(3, 0, 0);
    wait_free();
  endtask

  task automatic read_range(input int lo, input int hi);
    for (int a = lo; a <= hi; a++) cmd(0, a, 0);
    idle(1);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);

    tag = "R4";  // full pages with code 0
    for (int p = 0; p < 32; p++) page_write(p, 0, 16, 1);
    tag = "R2";
    read_range(0, 511);

    tag = "R3";  // single byte
    cmd(1, 12'h123, 8'h5a); cmd(3, 0, 0); wait_free();
    read_range(12'h120, 12'h12f);

    tag = "R4";  // wrap inside page, overwrite past 16 bytes
    page_write(5, 14, 4, 33);
    read_range(64, 111);
    page_write(6, 3, 20, 77);
    read_range(96, 111);

    tag = "R10";  // stray data/close, restart of open sequence
    cmd(2, 0, 8'hee); cmd(3, 0, 0); idle(3);
    cmd(1, 7*16, 8'h11); cmd(2, 0, 8'h22); cmd(1, 8*16 + 2, 8'h33); cmd(3, 0, 0); wait_free();
    read_range(7*16, 9*16 - 1);

    tag = "R6";  // commands during busy
    cmd(1, 9*16, 8'h99); cmd(2, 0, 8'h98); cmd(3, 0, 0);
    cmd(0, 9*16, 0); cmd(1, 10*16, 8'h44); cmd(2, 0, 8'h45); cmd(3, 0, 0);
    prot_code = 3'd3;
    cmd(0, 0, 0);
    wait_free();
    prot_code = 3'd0;
    read_range(9*16, 11*16 - 1);

    tag = "R7";
    for (int code = 1; code < 8; code++) begin
      prot_code = 3'(code);
      for (int k = 0; k < 12; k++) begin
        int pg;
        pg = (k * 3 + code) % 32;
        if (k == 0) pg = 3;
        if (k == 1) pg = 4;
        if (k == 2) pg = 23;
        if (k == 3) pg = 24;
        tag = "R8";
        page_write(pg, 0, 16, code * 16 + k);
        tag = "R7";
      end
      read_range(0, 511);
    end

    tag = "R9";  // reject then clear by new open
    prot_code = 3'd1;
    page_write(30, 0, 1, 5);
    idle(3);
    prot_code = 3'd4;
    cmd(1, 8*16, 8'h61); idle(2);
    cmd(3, 0, 0); wait_free();
    tag = "R8";
    read_range(30*16, 30*16);
    read_range(8*16, 8*16);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule